// File: doc/BRIEF.md
# Multi-Master I2C Arbitration Monitor

This block runs beside the transmitter of an I2C master that shares the bus with other masters. Bit by bit, it decides whether this master still owns the bus. The transmitter supplies the bit it wants on SDA and a flag saying a transfer is in progress. The block returns three things:

- an open-drain pull-down enable for SDA;
- a sticky flag that reports a lost arbitration;
- a grant for a requested START.

The block does not generate SCL and does not shift bytes. The SDA and SCL levels it receives are assumed to be already synchronized to `clk`.

The block watches the bus for START and STOP conditions and uses them to track whether the bus is free. A START request is granted only while the bus is free.

On each bit, the block makes one comparison, on the first sample after SCL goes high. The comparison fails only when this master released SDA (sent a 1) and the line reads low. On that first failure the block sets the loss flag and stops pulling SDA low for the rest of the transfer. When two masters send identical data, the comparisons never fail, so both can finish.

Top module: `i2c_arb_monitor`

## Requirements
- R1: While `rst` is high and on the first cycle after it: the bus counts as free, `arb_lost_o` is 0 and `sda_oe_o` is 0.
- R2: `start_ok_o` is the combinational AND of `start_req_i` and the bus-free state. A request is never granted while the bus is busy.
- R3: A START (two consecutive samples with SCL high and SDA going from 1 to 0) makes the bus busy from the next cycle. A STOP (the same, with SDA going from 0 to 1) makes it free from the next cycle.
- R4: `sda_oe_o` is 1 (pull SDA low) exactly when `tx_active_i` is 1, `tx_bit_i` is 0 and `arb_lost_o` is 0.
- R5: If, on the first sample with SCL high after a low sample, `tx_active_i` is 1, `tx_bit_i` is 1 and `sda_i` is 0, then `arb_lost_o` is 1 from the next cycle. `sda_oe_o` then stays 0 whatever `tx_bit_i` is.
- R6: When the sampled SDA equals `tx_bit_i` (0/0 or 1/1), no loss is flagged. This holds over any number of bits.
- R7: Only the first sample of each SCL high phase is compared. An SDA change later in the same high phase does not set `arb_lost_o`.
- R8: `arb_lost_o` stays set until `lost_clr_i` is 1 or a START request is granted. A loss detected in the same cycle as a clear wins, and the flag is set.
- R9: While `tx_active_i` is 0, no comparison is made and `arb_lost_o` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_active_i | input | 1 | Transfer in progress for this master |
| tx_bit_i | input | 1 | Bit this master wants on SDA (1 = release) |
| sda_i | input | 1 | Sampled SDA level |
| scl_i | input | 1 | Sampled SCL level |
| start_req_i | input | 1 | Request to issue a START |
| lost_clr_i | input | 1 | Software clear of the loss flag |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| arb_lost_o | output | 1 | Arbitration lost, sticky |
| start_ok_o | output | 1 | START request granted (bus free) |

## Verification
Two functions can fall in the same cycle: the software clear of the loss flag, and the detection of a new loss at an SCL rising sample. The bench first clears the flag. It then raises `lost_clr_i` on the exact sample where SCL rises with this master sending 1 and SDA low. The flag must read 1 on the next cycle, because a detected loss takes priority over the clear.

A second overlap is an SDA fall during an SCL high phase that has already been compared. The bench checks that this change only marks the bus busy and never creates a second, late comparison.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

    // Events seen on the shared lines in one clock cycle
    typedef struct packed {
        logic scl_rise;   // first high sample of an SCL high phase
        logic bus_start;  // SDA fell while SCL high
        logic bus_stop;   // SDA rose while SCL high
    } bus_evt_t;

    typedef enum logic [1:0] {
        VERDICT_IDLE  = 2'd0,
        VERDICT_MATCH = 2'd1,
        VERDICT_LOST  = 2'd2
    } verdict_t;

    // Outcome of one bit comparison
    function automatic verdict_t judge_bit(input logic eval,
                                           input logic sent,
                                           input logic seen);
        verdict_t v;
        if (!eval)
            v = VERDICT_IDLE;
        else if (sent && !seen)
            v = VERDICT_LOST;
        else
            v = VERDICT_MATCH;
        return v;
    endfunction

    // Open-drain pull-down request
    function automatic logic pull_low(input logic active,
                                      input logic sent,
                                      input logic lost);
        return active && !sent && !lost;
    endfunction

endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond
    import i2c_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o,
    output logic     bus_free_o
);

    logic scl_q;
    logic sda_q;
    logic free_q;

    // Previous-sample registers; no reset needed, they follow the lines
    always_ff @(posedge clk) begin
        scl_q <= scl_i;
        sda_q <= sda_i;
    end

    always_comb begin
        evt_o.scl_rise  = scl_i && !scl_q;
        evt_o.bus_start = scl_i && scl_q && sda_q && !sda_i;
        evt_o.bus_stop  = scl_i && scl_q && !sda_q && sda_i;
    end

    always_ff @(posedge clk) begin
        if (rst)
            free_q <= 1'b1;
        else if (evt_o.bus_start)
            free_q <= 1'b0;
        else if (evt_o.bus_stop)
            free_q <= 1'b1;
    end

    assign bus_free_o = free_q;

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (scl_i && $past(scl_i) && $past(sda_i) && !sda_i) |=> !bus_free_o); // R3

    AST_STOP_FREE: assert property (@(posedge clk) disable iff (rst)
        (scl_i && $past(scl_i) && !$past(sda_i) && sda_i) |=> bus_free_o); // R3

endmodule

// File: rtl/i2c_arb_cmp.sv
module i2c_arb_cmp
    import i2c_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt_i,
    input  logic     tx_active_i,
    input  logic     tx_bit_i,
    input  logic     sda_i,
    input  logic     clr_i,
    output logic     lost_o
);

    logic     lost_q;
    logic     eval;
    verdict_t verdict;

    // One evaluation per SCL high phase, only while transmitting and not lost
    assign eval    = evt_i.scl_rise && tx_active_i && !lost_q;
    assign verdict = judge_bit(eval, tx_bit_i, sda_i);

    // A detected loss takes priority over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            lost_q <= 1'b0;
        else if (verdict == VERDICT_LOST)
            lost_q <= 1'b1;
        else if (clr_i)
            lost_q <= 1'b0;
    end

    assign lost_o = lost_q;

    AST_LOSS_SETS: assert property (@(posedge clk) disable iff (rst)
        (evt_i.scl_rise && tx_active_i && tx_bit_i && !sda_i) |=> lost_o); // R5

    AST_MATCH_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (!lost_o && (!evt_i.scl_rise || !tx_active_i || (tx_bit_i == sda_i))) |=> !lost_o); // R6

    AST_LOST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (lost_o && !clr_i) |=> lost_o); // R8

endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor
    import i2c_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tx_active_i,
    input  logic tx_bit_i,
    input  logic sda_i,
    input  logic scl_i,
    input  logic start_req_i,
    input  logic lost_clr_i,
    output logic sda_oe_o,
    output logic arb_lost_o,
    output logic start_ok_o
);

    bus_evt_t evt;
    logic     bus_free;
    logic     lost;
    logic     clr;

    i2c_bus_cond u_cond (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .evt_o      (evt),
        .bus_free_o (bus_free)
    );

    // A granted START also opens a fresh arbitration
    assign start_ok_o = start_req_i && bus_free;
    assign clr        = lost_clr_i || start_ok_o;

    i2c_arb_cmp u_cmp (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (evt),
        .tx_active_i (tx_active_i),
        .tx_bit_i    (tx_bit_i),
        .sda_i       (sda_i),
        .clr_i       (clr),
        .lost_o      (lost)
    );

    assign arb_lost_o = lost;
    assign sda_oe_o   = pull_low(tx_active_i, tx_bit_i, lost);

    AST_ONE_EVAL: assert property (@(posedge clk) disable iff (rst)
        $rose(arb_lost_o) |-> ($past(scl_i) && !$past(scl_i, 2))); // R7

    AST_IDLE_NO_LOSS: assert property (@(posedge clk) disable iff (rst)
        (!tx_active_i && !arb_lost_o) |=> !arb_lost_o); // R9

endmodule

// File: tb/i2c_arb_monitor_test.sv
module i2c_arb_monitor_test;

    logic clk = 1'b0;
    logic rst;
    logic tx_active, tx_bit, sda, scl, start_req, lost_clr;
    logic sda_oe, arb_lost, start_ok;
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    always #5 clk = ~clk;

    i2c_arb_monitor uut (
        .clk         (clk),
        .rst         (rst),
        .tx_active_i (tx_active),
        .tx_bit_i    (tx_bit),
        .sda_i       (sda),
        .scl_i       (scl),
        .start_req_i (start_req),
        .lost_clr_i  (lost_clr),
        .sda_oe_o    (sda_oe),
        .arb_lost_o  (arb_lost),
        .start_ok_o  (start_ok)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // One bit: SDA set during SCL low, then one SCL high phase
    task automatic send_bit(input logic b, input logic seen);
        @(negedge clk); scl = 1'b0; tx_bit = b; sda = seen;
        @(negedge clk); scl = 1'b1;
        @(negedge clk);
        @(negedge clk); scl = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_start();
        @(negedge clk); scl = 1'b1; sda = 1'b1;
        @(negedge clk); sda = 1'b0;
        @(negedge clk);
        @(negedge clk); scl = 1'b0;
    endtask

    task automatic bus_stop();
        @(negedge clk); scl = 1'b0; sda = 1'b0;
        @(negedge clk); scl = 1'b1;
        @(negedge clk); sda = 1'b1;
        @(negedge clk);
    endtask

    task automatic clear_lost();
        @(negedge clk); lost_clr = 1'b1;
        @(negedge clk); lost_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; tx_active = 0; tx_bit = 1; sda = 1; scl = 1;
        start_req = 0; lost_clr = 0;
        repeat (4) @(negedge clk);
        chk("R1 lost in reset", arb_lost, 1'b0);
        chk("R1 oe in reset", sda_oe, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 lost after reset", arb_lost, 1'b0);
        chk("R1 oe after reset", sda_oe, 1'b0);
        start_req = 1'b1; #1;
        chk("R1 bus free after reset", start_ok, 1'b1);
        start_req = 1'b0;
    endtask

    task automatic t_grant();
        bus_start();
        @(negedge clk); start_req = 1'b1; #1;
        chk("R2 held off while busy", start_ok, 1'b0);
        chk("R3 start makes busy", start_ok, 1'b0);
        start_req = 1'b0;
        bus_stop();
        @(negedge clk); start_req = 1'b1; #1;
        chk("R3 stop frees bus", start_ok, 1'b1);
        chk("R2 granted when free", start_ok, 1'b1);
        start_req = 1'b0;
    endtask

    task automatic t_drive();
        @(negedge clk); tx_active = 1; tx_bit = 0; #1;
        chk("R4 pull low for 0", sda_oe, 1'b1);
        tx_bit = 1; #1;
        chk("R4 release for 1", sda_oe, 1'b0);
        tx_active = 0; tx_bit = 0; #1;
        chk("R4 idle no drive", sda_oe, 1'b0);
    endtask

    task automatic t_match();
        logic [7:0] d = 8'hA5;
        bus_start();
        tx_active = 1;
        for (int i = 7; i >= 0; i--) send_bit(d[i], d[i]);
        chk("R6 identical byte no loss", arb_lost, 1'b0);
        tx_active = 0;
        bus_stop();
    endtask

    task automatic t_loss();
        logic [7:0] d = 8'hF3;
        bus_start();
        tx_active = 1;
        for (int i = 7; i >= 3; i--) send_bit(d[i], d[i]);
        chk("R6 five matching bits", arb_lost, 1'b0);
        send_bit(1'b0, 1'b0);
        chk("R6 0 seen 0 no loss", arb_lost, 1'b0);
        send_bit(1'b1, 1'b0);
        chk("R5 loss on late bit", arb_lost, 1'b1);
        @(negedge clk); tx_bit = 0; #1;
        chk("R5 driver withdrawn", sda_oe, 1'b0);
        send_bit(1'b1, 1'b1);
        chk("R8 loss sticky", arb_lost, 1'b1);
        tx_active = 0;
        bus_stop();
    endtask

    task automatic t_clear();
        clear_lost();
        chk("R8 software clear", arb_lost, 1'b0);
        bus_start();
        tx_active = 1;
        send_bit(1'b1, 1'b0);
        chk("R5 loss again", arb_lost, 1'b1);
        tx_active = 0;
        bus_stop();
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
        chk("R8 grant clears loss", arb_lost, 1'b0);
    endtask

    task automatic t_collide();
        bus_start();
        tx_active = 1;
        @(negedge clk); scl = 0; tx_bit = 1; sda = 0;
        @(negedge clk); scl = 1; lost_clr = 1'b1;
        @(negedge clk); lost_clr = 1'b0;
        chk("R8 loss beats clear", arb_lost, 1'b1);
        @(negedge clk); scl = 0;
        tx_active = 0;
        clear_lost();
        bus_stop();
    endtask

    task automatic t_late_change();
        tx_active = 1;
        @(negedge clk); scl = 0; tx_bit = 1; sda = 1;
        @(negedge clk); scl = 1;
        @(negedge clk); sda = 0;
        @(negedge clk);
        @(negedge clk);
        chk("R7 late SDA fall ignored", arb_lost, 1'b0);
        scl = 0;
        tx_active = 0;
        bus_stop();
    endtask

    task automatic t_idle();
        bus_start();
        tx_active = 0;
        send_bit(1'b1, 1'b0);
        chk("R9 no compare when idle", arb_lost, 1'b0);
        bus_stop();
    endtask

    initial begin
        t_reset();
        t_grant();
        t_drive();
        t_match();
        t_loss();
        t_clear();
        t_collide();
        t_late_change();
        t_idle();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule